// File: doc/BRIEF.md
# Receiver Polling Controller

This block runs the power-saving schedule of a low-power radio receiver. While no transmitter is heard, the receiver repeats the same loop. It sleeps with its signal path switched off. It then powers the path and waits for the circuits to settle. Finally it starts a separate bit-check engine that judges whether the incoming edges look like a real transmission. When the check passes, the controller moves into receiving mode and keeps the path powered until told to stop. When the check fails, the controller goes back to sleep.

The sleep period is set by a 5-bit code, an extension factor of 1 or 8, and a base tick. Two code values have a special meaning: the all-ones code holds the receiver asleep indefinitely, and the zero code makes the receiver poll back to back. The extension can be standing or temporary. The temporary form clears itself the first time a check fails. An external enable pin and an OFF command let a host take the receiver out of receiving mode or park it in sleep.

Top module: `poll_ctrl`

## Requirements
- R1: After reset the controller is in sleep with all three outputs low, the sleep code is 11 and the extension factor is 1. With a base tick on every cycle, the path enable rises 11×1024+2 cycles after reset is released.
- R2: Once a sleep period is armed, it lasts code × factor × 1024 base ticks. The countdown advances only on cycles with `tick_i` high. Counted from the first cycle the controller is observed asleep, with a tick every cycle, the path enable stays low for code×factor×1024+2 cycles.
- R3: The extension factor is 8 when either `cfg_xstd_i` or `cfg_xtmp_i` was written as 1, and 1 otherwise.
- R4: The temporary extension bit clears itself on a failed check (check active, `chk_done_i`=1, `chk_pass_i`=0), unless a configuration write occurs in the same cycle. The next sleep then uses factor 1.
- R5: While the stored code is 31, the controller stays asleep. Writing any other code ends this state, and the new period starts counting in the cycle after the write is stored.
- R6: A stored code of 0 gives a sleep of zero ticks, so start-up follows after two sleep cycles.
- R7: Start-up keeps the path enable high for STARTUP_XCYC extended ticks (`xtick_i`). In the following cycle the check begins, and `chk_start_o` is high for exactly that one cycle.
- R8: During the check, `chk_done_i`=1 with `chk_pass_i`=1 enters receiving mode (`rx_mode_o`=1). With `chk_pass_i`=0 it returns to sleep and the path enable drops.
- R9: Receiving mode persists until `off_cmd_i` is high, after which the controller is in sleep on the next cycle.
- R10: `en_i` low forces sleep from every mode and holds the sleep timer unarmed. The sleep period starts from its full length in the cycle `en_i` returns high.
- R11: A code written while a sleep period is already counting does not change that period. It applies from the next entry into sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Base clock tick (sleep timing) |
| xtick_i | input | 1 | Extended clock tick (start-up timing) |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_code_i | input | CODE_W | Sleep code to store |
| cfg_xstd_i | input | 1 | Standing extension bit to store |
| cfg_xtmp_i | input | 1 | Temporary extension bit to store |
| chk_done_i | input | 1 | Bit-check engine result valid |
| chk_pass_i | input | 1 | Bit-check result: 1 pass, 0 fail |
| en_i | input | 1 | Enable pin, low forces and holds sleep |
| off_cmd_i | input | 1 | OFF command, leaves receiving mode |
| path_en_o | output | 1 | Signal-path enable (start-up, check, receiving) |
| chk_start_o | output | 1 | One-cycle start for the bit-check engine |
| rx_mode_o | output | 1 | Receiving-mode flag |

## Verification
All outputs are decoded from registers, so any stimulus shows up one clock after the edge that samples it. Going to sleep on a failed check, an OFF command or a low enable is visible at the next sampling point. A sleep period shows the path enable rising code×factor×1024+2 cycles after sleep is first observed, or one cycle later when a write ends the permanent-sleep state. The check start appears STARTUP_XCYC+1 cycles after the path enable rises. The bench drives inputs on the falling edge and compares against its reference model on every falling edge. It also counts these windows directly and checks them against the formulas above.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic [1:0] {
    PM_SLEEP   = 2'd0,
    PM_STARTUP = 2'd1,
    PM_CHECK   = 2'd2,
    PM_RECV    = 2'd3
  } poll_mode_e;
endpackage

// File: rtl/poll_cfg_regs.sv
module poll_cfg_regs #(
  parameter int CODE_W   = 5,
  parameter int RST_CODE = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              xstd_i,
  input  logic              xtmp_i,
  input  logic              chk_fail_i,
  output logic [CODE_W-1:0] code_o,
  output logic              ext_on_o,
  output logic              perm_o
);
  localparam int PERM_CODE = (1 << CODE_W) - 1;

  logic [CODE_W-1:0] code_q, code_n;
  logic              xstd_q, xstd_n;
  logic              xtmp_q, xtmp_n;
  logic              past_ok_q;

  always_comb begin
    code_n = code_q;
    xstd_n = xstd_q;
    xtmp_n = xtmp_q;
    if (wr_i) begin
      code_n = code_i;
      xstd_n = xstd_i;
      xtmp_n = xtmp_i;
    end else if (chk_fail_i) begin
      xtmp_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q    <= CODE_W'(RST_CODE);
      xstd_q    <= 1'b0;
      xtmp_q    <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      code_q    <= code_n;
      xstd_q    <= xstd_n;
      xtmp_q    <= xtmp_n;
      past_ok_q <= 1'b1;
    end
  end

  assign code_o   = code_q;
  assign ext_on_o = xstd_q | xtmp_q;
  assign perm_o   = (code_q == CODE_W'(PERM_CODE));

  // R4: a failed check without a concurrent write leaves the temporary bit clear
  assert_tmp_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && $past(chk_fail_i && !wr_i)) |-> !xtmp_q);
endmodule

// File: rtl/poll_sleep_timer.sv
module poll_sleep_timer #(
  parameter int CODE_W = 5,
  parameter int EXT    = 8,
  parameter int UNIT   = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_sleep_i,
  input  logic              hold_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              ext_on_i,
  output logic              expired_o
);
  localparam int EXT_W  = $clog2(EXT);
  localparam int UNIT_W = $clog2(UNIT);
  localparam int CNT_W  = CODE_W + EXT_W + UNIT_W;

  logic             armed_q, armed_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] dur;

  assign dur = CNT_W'(code_i) * (ext_on_i ? CNT_W'(EXT) : CNT_W'(1)) * CNT_W'(UNIT);

  always_comb begin
    armed_n = armed_q;
    cnt_n   = cnt_q;
    if (!in_sleep_i || hold_i) begin
      armed_n = 1'b0;
    end else if (!armed_q) begin
      armed_n = 1'b1;
      cnt_n   = dur;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_n;
      cnt_q   <= cnt_n;
    end
  end

  assign expired_o = in_sleep_i && !hold_i && armed_q && (cnt_q == '0);

  // R2: an armed countdown only moves on a base tick
  assert_count_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sleep_i && !hold_i && armed_q && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/poll_startup_timer.sv
module poll_startup_timer #(
  parameter int XCYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_startup_i,
  input  logic xtick_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(XCYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (!in_startup_i) begin
      cnt_n = CNT_W'(XCYC);
    end else if (xtick_i && (cnt_q != '0)) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(XCYC);
    else        cnt_q <= cnt_n;
  end

  assign done_o = in_startup_i && (cnt_q == '0);

  // R7: start-up never finishes in its first cycle when XCYC is nonzero
  assert_no_instant_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (XCYC > 0 && !in_startup_i) |=> (cnt_q == CNT_W'(XCYC)));
endmodule

// File: rtl/poll_ctrl.sv
module poll_ctrl
  import poll_pkg::*;
#(
  parameter int CODE_W         = 5,
  parameter int RST_CODE       = 11,
  parameter int EXT_FACTOR     = 8,
  parameter int TICKS_PER_UNIT = 1024,
  parameter int STARTUP_XCYC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              xtick_i,
  input  logic              cfg_wr_i,
  input  logic [CODE_W-1:0] cfg_code_i,
  input  logic              cfg_xstd_i,
  input  logic              cfg_xtmp_i,
  input  logic              chk_done_i,
  input  logic              chk_pass_i,
  input  logic              en_i,
  input  logic              off_cmd_i,
  output logic              path_en_o,
  output logic              chk_start_o,
  output logic              rx_mode_o
);
  poll_mode_e        mode_q, mode_n;
  logic              start_q, start_n;
  logic              past_ok_q;
  logic [CODE_W-1:0] code;
  logic              ext_on, perm, chk_fail, hold;
  logic              slp_expired, su_done;

  assign chk_fail = (mode_q == PM_CHECK) && en_i && chk_done_i && !chk_pass_i;
  assign hold     = !en_i || perm;

  poll_cfg_regs #(.CODE_W(CODE_W), .RST_CODE(RST_CODE)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i), .code_i(cfg_code_i),
    .xstd_i(cfg_xstd_i), .xtmp_i(cfg_xtmp_i), .chk_fail_i(chk_fail),
    .code_o(code), .ext_on_o(ext_on), .perm_o(perm));

  poll_sleep_timer #(.CODE_W(CODE_W), .EXT(EXT_FACTOR), .UNIT(TICKS_PER_UNIT)) u_sleep (
    .clk(clk), .rst_n(rst_n), .in_sleep_i(mode_q == PM_SLEEP), .hold_i(hold),
    .tick_i(tick_i), .code_i(code), .ext_on_i(ext_on), .expired_o(slp_expired));

  poll_startup_timer #(.XCYC(STARTUP_XCYC)) u_startup (
    .clk(clk), .rst_n(rst_n), .in_startup_i(mode_q == PM_STARTUP),
    .xtick_i(xtick_i), .done_o(su_done));

  always_comb begin
    mode_n  = mode_q;
    start_n = 1'b0;
    if (!en_i) begin
      mode_n = PM_SLEEP;
    end else begin
      case (mode_q)
        PM_SLEEP:   if (slp_expired) mode_n = PM_STARTUP;
        PM_STARTUP: if (su_done) begin
                      mode_n  = PM_CHECK;
                      start_n = 1'b1;
                    end
        PM_CHECK:   if (chk_done_i) mode_n = chk_pass_i ? PM_RECV : PM_SLEEP;
        PM_RECV:    if (off_cmd_i) mode_n = PM_SLEEP;
        default:    mode_n = PM_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= PM_SLEEP;
      start_q   <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      mode_q    <= mode_n;
      start_q   <= start_n;
      past_ok_q <= 1'b1;
    end
  end

  assign path_en_o   = (mode_q != PM_SLEEP);
  assign rx_mode_o   = (mode_q == PM_RECV);
  assign chk_start_o = start_q;

  assert_start_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_start_o |=> !chk_start_o);
  assert_start_in_check_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_start_o |-> (path_en_o && !rx_mode_o));
  assert_recv_on_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && $rose(rx_mode_o)) |-> $past(chk_done_i && chk_pass_i));
  assert_off_leaves_recv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode_o && off_cmd_i) |=> !rx_mode_o);
  assert_perm_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!path_en_o && perm) |=> !path_en_o);
  assert_enable_forces_sleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && !$past(en_i)) |-> !path_en_o);
endmodule

// File: tb/poll_ctrl_tb.sv
module poll_ctrl_tb_top;
  localparam int SU = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1, xtick = 1'b1, wr = 1'b0;
  logic [4:0] code = 5'd0;
  logic       xstd = 1'b0, xtmp = 1'b0, done = 1'b0, pass = 1'b0;
  logic       en = 1'b1, off = 1'b0;
  logic       path_en, chk_start, rx_mode;

  int    n_checks = 0, n_err = 0, cyc = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  always #2.5 clk = ~clk;

  poll_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .xtick_i(xtick), .cfg_wr_i(wr),
    .cfg_code_i(code), .cfg_xstd_i(xstd), .cfg_xtmp_i(xtmp),
    .chk_done_i(done), .chk_pass_i(pass), .en_i(en), .off_cmd_i(off),
    .path_en_o(path_en), .chk_start_o(chk_start), .rx_mode_o(rx_mode));

  // behavioural reference: mode 0 sleep, 1 start-up, 2 check, 3 receive
  int m_mode, m_rem, m_code, m_su;
  bit m_armed, m_std, m_tmp, m_start;

  always @(posedge clk or negedge rst_n) begin : mdl
    bit fail, holdv, expired, sudone;
    int nm;
    if (!rst_n) begin
      m_mode = 0; m_armed = 0; m_rem = 0; m_code = 11;
      m_std = 0; m_tmp = 0; m_su = SU; m_start = 0;
    end else begin
      fail    = (m_mode == 2) && en && done && !pass;
      holdv   = !en || (m_code == 31);
      expired = (m_mode == 0) && m_armed && (m_rem == 0) && !holdv;
      sudone  = (m_mode == 1) && (m_su == 0);
      nm = m_mode;
      m_start = 0;
      if (!en) nm = 0;
      else if (m_mode == 0 && expired) nm = 1;
      else if (m_mode == 1 && sudone) begin nm = 2; m_start = 1; end
      else if (m_mode == 2 && done) nm = pass ? 3 : 0;
      else if (m_mode == 3 && off) nm = 0;
      if (m_mode != 0 || holdv) m_armed = 0;
      else if (!m_armed) begin
        m_armed = 1;
        m_rem = m_code * ((m_std || m_tmp) ? 8 : 1) * 1024;
      end else if (tick && m_rem > 0) m_rem--;
      if (m_mode != 1) m_su = SU;
      else if (xtick && m_su > 0) m_su--;
      if (wr) begin m_code = code; m_std = xstd; m_tmp = xtmp; end
      else if (fail) m_tmp = 0;
      m_mode = nm;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!finished) begin
      chk(path_en == (m_mode != 0), cur_req, "path_en vs model", int'(path_en), int'(m_mode != 0));
      chk(rx_mode == (m_mode == 3), cur_req, "rx_mode vs model", int'(rx_mode), int'(m_mode == 3));
      chk(chk_start == m_start, cur_req, "chk_start vs model", int'(chk_start), int'(m_start));
    end
  end

  task automatic wait_rise(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!path_en && n < 20000);
  endtask

  task automatic wait_start(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!chk_start && n < 100);
  endtask

  // waits for the check start, answers it, optionally writes config in that cycle
  task automatic run_check(input bit p, input bit w, input logic [4:0] c,
                           input bit s, input bit t);
    int n;
    wait_start(n);
    chk(n == SU + 1, "R7", "start-up length", n, SU + 1);
    done = 1'b1; pass = p;
    wr = w; code = c; xstd = s; xtmp = t;
    @(negedge clk);
    done = 1'b0; pass = 1'b0; wr = 1'b0;
    chk(rx_mode == p, "R8", "rx_mode after result", int'(rx_mode), int'(p));
    chk(path_en == p, "R8", "path_en after result", int'(path_en), int'(p));
  endtask

  task automatic expect_rise(input string req, input int exp);
    int n;
    cur_req = req;
    wait_rise(n);
    chk(n == exp, req, "sleep length", n, exp);
  endtask

  initial begin
    int n;
    #1;
    chk(!path_en && !chk_start && !rx_mode, "R1", "outputs in reset",
        {29'd0, path_en, chk_start, rx_mode}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_rise("R1", 11 * 1024 + 2);

    cur_req = "R2";
    run_check(0, 1, 5'd1, 0, 0);
    expect_rise("R2", 1024 + 2);

    cur_req = "R11";
    run_check(0, 0, 5'd0, 0, 0);
    wr = 1'b1; code = 5'd2;
    @(negedge clk); wr = 1'b0;
    wait_rise(n);
    chk(n == 1024 + 1, "R11", "running period unchanged", n, 1024 + 1);
    run_check(0, 0, 5'd0, 0, 0);
    expect_rise("R11", 2048 + 2);

    cur_req = "R3";
    run_check(0, 1, 5'd1, 1, 0);
    expect_rise("R3", 8192 + 2);

    cur_req = "R8";
    run_check(1, 1, 5'd1, 0, 1);
    repeat (20) @(negedge clk);
    chk(rx_mode == 1'b1, "R9", "receive persists", int'(rx_mode), 1);
    off = 1'b1;
    @(negedge clk); off = 1'b0;
    chk(rx_mode == 1'b0, "R9", "off command leaves receive", int'(rx_mode), 0);
    expect_rise("R3", 8192 + 2);

    cur_req = "R4";
    run_check(0, 0, 5'd0, 0, 0);
    expect_rise("R4", 1024 + 2);

    cur_req = "R6";
    run_check(0, 1, 5'd0, 0, 0);
    expect_rise("R6", 2);
    run_check(0, 0, 5'd0, 0, 0);
    expect_rise("R6", 2);

    cur_req = "R5";
    run_check(0, 1, 5'd31, 0, 0);
    repeat (3000) @(negedge clk);
    chk(path_en == 1'b0, "R5", "permanent sleep holds", int'(path_en), 0);
    wr = 1'b1; code = 5'd1;
    @(negedge clk); wr = 1'b0;
    wait_rise(n);
    chk(n == 1024 + 2, "R5", "exit from permanent sleep", n + 1, 1024 + 3);

    cur_req = "R10";
    run_check(1, 0, 5'd0, 0, 0);
    en = 1'b0;
    @(negedge clk);
    chk(!rx_mode && !path_en, "R10", "enable low leaves receive",
        {30'd0, rx_mode, path_en}, 0);
    repeat (9) @(negedge clk);
    en = 1'b1;
    expect_rise("R10", 1024 + 2);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(path_en == 1'b0, "R10", "enable low ends start-up", int'(path_en), 0);
    en = 1'b1;
    expect_rise("R10", 1024 + 2);

    cur_req = "R2";
    run_check(0, 0, 5'd0, 0, 0);
    n = 0;
    do begin @(negedge clk); tick = ~tick; n++; end while (!path_en && n < 5000);
    tick = 1'b1;
    chk(n > 2000 && n < 2100, "R2", "gated ticks stretch sleep", n, 2050);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_err++;
      $display("FAIL %s watchdog: actual %0d expected %0d", cur_req, cyc, 190000);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule